// File: doc/BRIEF.md
# Compressed Opcode Page Tracker

This block keeps track of which opcode page the decoder of 16-bit compressed instructions should use. The 11-bit payload of a compressed instruction is too small to hold every useful operation. A page-select instruction therefore names a page and says how many later instructions that page covers. The tracker has a small number of independent slots, two by default, one for each compressed sub-opcode that can hold its own page. Each slot stores a page number, a remaining count and a valid flag.

Each retired instruction that is not a page-select uses up one unit of the count in every live slot. When the count runs out, the page lapses. A taken branch cancels every slot at once. A length of all ones marks a page that never lapses through counting. Each slot's whole state can be read and written as one CSR word. This lets the state be saved and restored around a trap, for example. The decoder reads the page number and the valid flag of each slot straight from the outputs.

Top module: `cpage_tracker`

## Requirements
- R1: After reset, every slot has valid 0, count 0 and page 0, and this shows on page_vld_o, page_num_o and csr_rdata.
- R2: A retiring page-select (ret_vld=1, ret_sel=1) loads ret_page and ret_len into the slot picked by ret_slot at the next edge. That slot becomes valid only if ret_len is nonzero. Other slots keep their page and count.
- R3: Each retiring instruction with ret_sel=0 takes one from the count of every valid slot whose count is 1 to 14. A slot reaching count 0 shows page_vld_o low from the cycle after that retire, so a length L covers exactly L counted retires.
- R4: A valid slot with count 15 (all ones) keeps its count and stays valid across any number of retires.
- R5: br_taken=1 clears valid and count of every slot at the next edge, whatever count remains. The page number is kept.
- R6: A page-select and a taken branch in the same cycle leave the targeted slot loaded with the new page and clear the other slots.
- R7: A page-select aimed at a slot that is already active replaces both its page and its remaining count.
- R8: csr_we=1 loads csr_wdata into the slot named by csr_slot at the next edge. The layout is bits [3:0] page, bits [7:4] count and bit 8 valid (PAGE_W=4, LEN_W=4). The write takes priority over a same-cycle select, retire or branch for that slot.
- R9: csr_rdata shows, in the same cycle and with the R8 layout, the state of the slot named by csr_slot.
- R10: While ret_vld=0, ret_sel, ret_slot, ret_page and ret_len have no effect. A slot that is not valid keeps its count across retires.
- R11: Bits [i*PAGE_W +: PAGE_W] of page_num_o and bit i of page_vld_o give the page and the valid flag of slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_sel | input | 1 | The retiring instruction is a page-select |
| ret_slot | input | SLOT_W | Slot targeted by the page-select |
| ret_page | input | PAGE_W | Page number carried by the page-select |
| ret_len | input | LEN_W | Activation length carried by the page-select |
| br_taken | input | 1 | A taken branch retires this cycle |
| csr_we | input | 1 | CSR write strobe |
| csr_slot | input | SLOT_W | Slot addressed by the CSR read and the CSR write |
| csr_wdata | input | CSR_W | CSR write word {valid, count, page} |
| csr_rdata | output | CSR_W | CSR read word of the addressed slot |
| page_num_o | output | NUM_SLOTS*PAGE_W | Page number of each slot |
| page_vld_o | output | NUM_SLOTS | Page-valid flag of each slot |

## Verification
A wrong count or a missed decrement cannot be seen while the page is still active. It shows up later as page_vld_o dropping one or more retires early or late, so the bench compares every slot after every cycle. A count that goes wrong in a slot that is not valid stays hidden at the decoder outputs. csr_rdata is the only place it shows, so each cycle's check also reads every slot back through the CSR port. A bad priority between write, select, branch and retire shows in the very next cycle.

// File: rtl/cpage_pkg.sv
package cpage_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CSR,
        ACT_SEL,
        ACT_KILL,
        ACT_STEP
    } slot_act_e;

    // Priority per slot: CSR write, then own page-select, then branch, then count.
    function automatic slot_act_e pick_act(logic wr, logic sel, logic kill, logic step);
        if (wr)        return ACT_CSR;
        else if (sel)  return ACT_SEL;
        else if (kill) return ACT_KILL;
        else if (step) return ACT_STEP;
        else           return ACT_HOLD;
    endfunction

endpackage

// File: rtl/cpage_route.sv
module cpage_route #(
    parameter int NUM_SLOTS = 2,
    parameter int SLOT_W    = 1
) (
    input  logic                 ret_vld,
    input  logic                 ret_sel,
    input  logic [SLOT_W-1:0]    ret_slot,
    input  logic                 br_taken,
    input  logic                 csr_we,
    input  logic [SLOT_W-1:0]    csr_slot,
    output logic [NUM_SLOTS-1:0] wr_o,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic                 step_o,
    output logic                 kill_o
);
    logic sel_any;

    assign sel_any = ret_vld && ret_sel;
    assign step_o  = ret_vld && !ret_sel;
    assign kill_o  = br_taken;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
        localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);
        assign wr_o[g]  = csr_we  && (csr_slot == IDX);
        assign sel_o[g] = sel_any && (ret_slot == IDX);
    end
endmodule

// File: rtl/cpage_slot.sv
module cpage_slot
    import cpage_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_vld_i,
    input  logic [LEN_W-1:0]  wr_cnt_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic              sel_i,
    input  logic [PAGE_W-1:0] sel_page_i,
    input  logic [LEN_W-1:0]  sel_len_i,
    input  logic              kill_i,
    input  logic              step_i,
    output logic              vld_o,
    output logic [LEN_W-1:0]  cnt_o,
    output logic [PAGE_W-1:0] page_o
);
    localparam logic [LEN_W-1:0] LEN_PERM = '1;
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    typedef struct packed {
        logic              vld;
        logic [LEN_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
    } slot_st_t;

    slot_st_t  st_d, st_q;
    slot_act_e act;

    always_comb begin
        st_d = st_q;
        act  = pick_act(wr_i, sel_i, kill_i, step_i);
        case (act)
            ACT_CSR: begin
                st_d.vld  = wr_vld_i;
                st_d.cnt  = wr_cnt_i;
                st_d.page = wr_page_i;
            end
            ACT_SEL: begin
                st_d.vld  = (sel_len_i != '0);
                st_d.cnt  = sel_len_i;
                st_d.page = sel_page_i;
            end
            ACT_KILL: begin
                st_d.vld = 1'b0;
                st_d.cnt = '0;
            end
            ACT_STEP: begin
                if (st_q.vld && st_q.cnt != LEN_PERM) begin
                    if (st_q.cnt <= LEN_ONE) begin
                        st_d.vld = 1'b0;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt - LEN_ONE;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign cnt_o  = st_q.cnt;
    assign page_o = st_q.page;

    p_csr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.vld == $past(wr_vld_i) && st_q.cnt == $past(wr_cnt_i)
                  && st_q.page == $past(wr_page_i)));

    p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i) |=> (st_q.page == $past(sel_page_i) && st_q.cnt == $past(sel_len_i)));

    p_branch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && !wr_i && !sel_i) |=> (!st_q.vld && st_q.cnt == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && !sel_i && !kill_i && st_q.vld && st_q.cnt > LEN_ONE
         && st_q.cnt != LEN_PERM) |=> (st_q.vld && st_q.cnt == $past(st_q.cnt) - LEN_ONE));

    p_perm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.cnt == LEN_PERM && !wr_i && !sel_i && !kill_i)
        |=> (st_q.vld && st_q.cnt == LEN_PERM));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.vld && !wr_i && !sel_i) |=> $stable(st_q.page));
endmodule

// File: rtl/cpage_csr_mux.sv
module cpage_csr_mux #(
    parameter int NUM_SLOTS = 2,
    parameter int SLOT_W    = 1,
    parameter int PAGE_W    = 4,
    parameter int LEN_W     = 4,
    parameter int CSR_W     = 1 + LEN_W + PAGE_W
) (
    input  logic [SLOT_W-1:0]           csr_slot,
    input  logic [NUM_SLOTS-1:0]        vld_i,
    input  logic [NUM_SLOTS*LEN_W-1:0]  cnt_i,
    input  logic [NUM_SLOTS*PAGE_W-1:0] page_i,
    output logic [CSR_W-1:0]            rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (csr_slot == SLOT_W'(i)) begin
                rdata_o = {vld_i[i], cnt_i[i*LEN_W +: LEN_W], page_i[i*PAGE_W +: PAGE_W]};
            end
        end
    end
endmodule

// File: rtl/cpage_tracker.sv
module cpage_tracker #(
    parameter int NUM_SLOTS = 2,
    parameter int PAGE_W    = 4,
    parameter int LEN_W     = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CSR_W    = 1 + LEN_W + PAGE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ret_vld,
    input  logic                        ret_sel,
    input  logic [SLOT_W-1:0]           ret_slot,
    input  logic [PAGE_W-1:0]           ret_page,
    input  logic [LEN_W-1:0]            ret_len,
    input  logic                        br_taken,
    input  logic                        csr_we,
    input  logic [SLOT_W-1:0]           csr_slot,
    input  logic [CSR_W-1:0]            csr_wdata,
    output logic [CSR_W-1:0]            csr_rdata,
    output logic [NUM_SLOTS*PAGE_W-1:0] page_num_o,
    output logic [NUM_SLOTS-1:0]        page_vld_o
);
    logic [NUM_SLOTS-1:0]       wr, sel;
    logic                       step, kill;
    logic [NUM_SLOTS*LEN_W-1:0] cnt_all;

    cpage_route #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_route (
        .ret_vld  (ret_vld),
        .ret_sel  (ret_sel),
        .ret_slot (ret_slot),
        .br_taken (br_taken),
        .csr_we   (csr_we),
        .csr_slot (csr_slot),
        .wr_o     (wr),
        .sel_o    (sel),
        .step_o   (step),
        .kill_o   (kill)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        cpage_slot #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr[g]),
            .wr_vld_i   (csr_wdata[CSR_W-1]),
            .wr_cnt_i   (csr_wdata[PAGE_W +: LEN_W]),
            .wr_page_i  (csr_wdata[PAGE_W-1:0]),
            .sel_i      (sel[g]),
            .sel_page_i (ret_page),
            .sel_len_i  (ret_len),
            .kill_i     (kill),
            .step_i     (step),
            .vld_o      (page_vld_o[g]),
            .cnt_o      (cnt_all[g*LEN_W +: LEN_W]),
            .page_o     (page_num_o[g*PAGE_W +: PAGE_W])
        );
    end

    cpage_csr_mux #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .PAGE_W    (PAGE_W),
        .LEN_W     (LEN_W),
        .CSR_W     (CSR_W)
    ) u_csr_mux (
        .csr_slot (csr_slot),
        .vld_i    (page_vld_o),
        .cnt_i    (cnt_all),
        .page_i   (page_num_o),
        .rdata_o  (csr_rdata)
    );
endmodule

// File: tb/cpage_tracker_test.sv
module cpage_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ret_vld = 1'b0, ret_sel = 1'b0, br_taken = 1'b0, csr_we = 1'b0;
    logic [0:0] ret_slot = '0, csr_slot = '0;
    logic [3:0] ret_page = '0, ret_len = '0;
    logic [8:0] csr_wdata = '0;
    logic [8:0] csr_rdata;
    logic [7:0] page_num_o;
    logic [1:0] page_vld_o;

    logic       mv [NS];
    logic [3:0] mc [NS];
    logic [3:0] mp [NS];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpage_tracker uut (
        .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_sel(ret_sel),
        .ret_slot(ret_slot), .ret_page(ret_page), .ret_len(ret_len),
        .br_taken(br_taken), .csr_we(csr_we), .csr_slot(csr_slot),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .page_num_o(page_num_o), .page_vld_o(page_vld_o)
    );

    // Reference from the requirements: CSR write, own select, branch, counted retire.
    task automatic model_update();
        for (int i = 0; i < NS; i++) begin
            if (csr_we && csr_slot == 1'(i)) begin
                mv[i] = csr_wdata[8]; mc[i] = csr_wdata[7:4]; mp[i] = csr_wdata[3:0];
            end else if (ret_vld && ret_sel && ret_slot == 1'(i)) begin
                mp[i] = ret_page; mc[i] = ret_len; mv[i] = (ret_len != 0);
            end else if (br_taken) begin
                mv[i] = 1'b0; mc[i] = 4'd0;
            end else if (ret_vld && !ret_sel && mv[i] && mc[i] != 4'd15) begin
                if (mc[i] <= 4'd1) begin mc[i] = 4'd0; mv[i] = 1'b0; end
                else mc[i] = mc[i] - 4'd1;
            end
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < NS; i++) begin
            logic [8:0] exp;
            csr_slot = 1'(i);
            #1;
            exp = {mv[i], mc[i], mp[i]};
            checks++;
            if (csr_rdata !== exp || page_vld_o[i] !== mv[i] || page_num_o[i*4 +: 4] !== mp[i]) begin
                errors++;
                $display("FAIL %s slot %0d actual rdata=%h vld=%b page=%h expected rdata=%h vld=%b page=%h",
                         tag, i, csr_rdata, page_vld_o[i], page_num_o[i*4 +: 4], exp, mv[i], mp[i]);
            end
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_update();
        #1;
        ret_vld = 0; ret_sel = 0; br_taken = 0; csr_we = 0;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_sel(int s, int pg, int ln);
        ret_vld = 1; ret_sel = 1; ret_slot = 1'(s); ret_page = 4'(pg); ret_len = 4'(ln);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin mv[i] = 0; mc[i] = 0; mp[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 R11");

        // Full sweep of lengths on each slot, counting down with retires.
        for (int s = 0; s < NS; s++) begin
            for (int ln = 0; ln < 16; ln++) begin
                do_sel(s, ln ^ 4'h5, ln);
                step("R2 R11");
                for (int k = 0; k < 16; k++) begin
                    ret_vld = 1;
                    step(ln == 15 ? "R4" : "R3");
                end
                br_taken = 1;
                step("R5");
            end
        end

        // Overwrite an active page.
        do_sel(0, 3, 5); step("R2");
        ret_vld = 1; step("R3");
        ret_vld = 1; step("R3");
        do_sel(0, 9, 3); step("R7");
        for (int k = 0; k < 4; k++) begin ret_vld = 1; step("R7"); end

        // Branch cancels all slots, including a permanent one.
        do_sel(0, 1, 15); step("R2");
        do_sel(1, 2, 9);  step("R2");
        br_taken = 1;     step("R5");

        // Select and branch together.
        do_sel(0, 4, 15); step("R2");
        do_sel(1, 6, 7); br_taken = 1; step("R6");
        do_sel(0, 8, 2); br_taken = 1; step("R6");

        // Inputs ignored without ret_vld; idle slot count survives retires.
        do_sel(1, 5, 6); step("R2");
        ret_vld = 0; ret_sel = 1; ret_slot = 1'b1; ret_page = 4'hC; ret_len = 4'd2;
        step("R10");
        csr_we = 1; csr_slot = 1'b0; csr_wdata = {1'b0, 4'd7, 4'hA}; step("R8");
        for (int k = 0; k < 3; k++) begin ret_vld = 1; step("R10"); end

        // CSR write sweep over every word, with competing events.
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < 512; w++) begin
                csr_we = 1; csr_slot = 1'(s); csr_wdata = 9'(w);
                if (w % 3 == 0) do_sel(s, 15 - (w % 16), w % 16);
                if (w % 5 == 0) br_taken = 1;
                if (w % 3 == 1) ret_vld = 1;
                step("R8 R9");
                ret_vld = 1;
                step("R3 R9");
            end
        end

        // Mixed traffic.
        for (int k = 0; k < 4000; k++) begin
            int r = $urandom_range(0, 99);
            ret_vld  = (r < 80);
            ret_sel  = (r < 15);
            ret_slot = 1'($urandom_range(0, 1));
            ret_page = 4'($urandom_range(0, 15));
            ret_len  = 4'($urandom_range(0, 15));
            br_taken = (r >= 95);
            csr_we   = ($urandom_range(0, 49) == 0);
            csr_slot = 1'($urandom_range(0, 1));
            csr_wdata = 9'($urandom_range(0, 511));
            step("R11 R3 R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule